// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block creates the timing for a synchronous serial audio port. It makes a bit clock and a frame-sync pulse. Everything runs in the system clock domain. The bit clock is produced as a level (`bclk`) together with a one-cycle strobe (`bclk_rise`) that marks each of its rising edges. Downstream shifters use the strobe as a clock enable. The bit clock comes from one of two sources:
- an internal programmable divider of the system clock;
- an external serial clock pin, which passes through a synchronizer first.

Frame sync is counted in bit clocks. The frame length is `period`+1 bit clocks, and sync stays active for the first `width`+1 bit clocks of each frame. A `frame_start` strobe marks the first bit clock of every frame. Two enables bring the block up in order: `gen_en` starts the clock stage, and `fs_en` then starts the sync stage. A mode pin selects the sync source:
- periodic frames, back to back;
- one frame per transmit-load request.

The block has no data path and therefore no valid/ready stream. All pins are plain control and status levels or strobes. There is no back-pressure: a `frame_start` or `bclk_rise` strobe lasts exactly one system clock, and the consumer must take it in that cycle.

Top module: `fsync_gen`

## Requirements
- R1: With `ext_sel`=0 and `gen_en`=1, `bclk` toggles every `clk_div`+1 system clocks, so `bclk_rise` pulses once every 2*(`clk_div`+1) clocks. A `clk_div` of 0 toggles `bclk` on every clock.
- R2: With `ext_sel`=1, `bclk` follows `ext_clk` after a two-flop synchronizer, and `bclk_rise` pulses once per rising edge of `ext_clk`. `clk_div` is then unused.
- R3: In periodic mode (`sync_mode`=1), `frame_start` pulses once every `period`+1 bit clocks (12-bit field, frame length minus one). It pulses one system clock after the `bclk_rise` that opens the frame.
- R4: `fsync` is 1 during bit clocks 0..`width` of each frame (8-bit field, active length minus one) and 0 for the rest of the frame. `fsync` rises only together with `frame_start`.
- R5: A `width` greater than or equal to `period` holds `fsync` at 1 through the whole frame and across frame boundaries, while `frame_start` still marks every frame.
- R6: While `fs_en`=0, `fsync` and `frame_start` stay 0 even though the bit clock runs. After `fs_en` rises, the first `bclk_rise` opens frame 0.
- R7: While `gen_en`=0, `bclk`, `bclk_rise`, `fsync` and `frame_start` are all 0 from the next clock onward, whatever the state of `fs_en`.
- R8: In transmit-tied mode (`sync_mode`=0), each `tx_load` pulse requests exactly one frame. The frame opens at the first free bit clock, and a request made during a frame chains the next frame directly after it. With no request pending, `fsync` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Clock-stage enable; 0 holds clock and sync stages cleared |
| fs_en | input | 1 | Sync-stage enable; 0 holds frame sync cleared |
| ext_sel | input | 1 | 1 selects the external clock pin as bit-clock source |
| ext_clk | input | 1 | External serial clock, asynchronous |
| clk_div | input | 8 | Internal divider setting (half bit period minus one) |
| period | input | 12 | Frame length in bit clocks minus one |
| width | input | 8 | Sync active length in bit clocks minus one |
| sync_mode | input | 1 | 1 periodic frames, 0 one frame per transmit request |
| tx_load | input | 1 | Transmit-load request strobe, used when `sync_mode`=0 |
| bclk | output | 1 | Bit clock level |
| bclk_rise | output | 1 | One-cycle strobe on each bit-clock rising edge |
| fsync | output | 1 | Frame sync, active high |
| frame_start | output | 1 | One-cycle strobe on the first bit clock of each frame |

## Verification
The closing bit clock of one frame and a waiting transmit request meet on the same tick in transmit-tied mode. That tick both ends the current frame and opens the next, so it must produce `frame_start` with no idle bit clock in between. The bench provokes this by issuing a second `tx_load` a few cycles into a frame. The scoreboard then expects two frames of sync pattern back to back, followed by idle zeros. Any gap, or any extra frame, shows up as a mismatch on the per-bit-clock `fsync`/`frame_start` pair.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned PER_W    = 12;
  localparam int unsigned WID_W    = 8;
  localparam int unsigned SYNC_LEN = 2;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;

  typedef enum logic {
    SYNC_ON_TX   = 1'b0,
    SYNC_PERIOD  = 1'b1
  } sync_kind_e;
endpackage

// File: rtl/fsg_clkdiv.sv
module fsg_clkdiv #(
  parameter int unsigned DW    = 8,
  parameter int unsigned NSYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          use_ext,
  input  logic          ext_clk,
  input  logic [DW-1:0] div,
  output logic          bit_lvl,
  output logic          bit_rise
);
  localparam int unsigned LAST = NSYNC - 1;

  logic [DW-1:0]    cnt;
  logic [NSYNC-1:0] sync_sh;
  logic             term;

  assign term = (cnt == div);

  // synchronizer stages for the external clock pin
  genvar g;
  generate
    for (g = 0; g < int'(NSYNC); g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_sh[g] <= 1'b0;
          else        sync_sh[g] <= ext_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_sh[g] <= 1'b0;
          else        sync_sh[g] <= sync_sh[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bit_lvl  <= 1'b0;
      bit_rise <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      bit_lvl  <= 1'b0;
      bit_rise <= 1'b0;
    end else if (use_ext) begin
      cnt      <= '0;
      bit_lvl  <= sync_sh[LAST];
      bit_rise <= sync_sh[LAST] & ~bit_lvl;
    end else begin
      bit_rise <= term & ~bit_lvl;
      if (term) begin
        cnt     <= '0;
        bit_lvl <= ~bit_lvl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsg_framer.sv
module fsg_framer #(
  parameter int unsigned PW = 12,
  parameter int unsigned WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  input  logic          periodic,
  input  logic          req,
  input  logic [PW-1:0] per,
  input  logic [WW-1:0] wid,
  output logic          sync_o,
  output logic          start_o
);
  localparam int unsigned PAD = PW - WW;

  logic [PW-1:0] pos;
  logic [PW-1:0] nxt;
  logic [PW-1:0] wid_ext;
  logic          running;
  logic          pend;
  logic          at_end;
  logic          want;

  assign nxt     = pos + 1'b1;
  assign wid_ext = {{PAD{1'b0}}, wid};
  assign at_end  = running && (pos == per);
  assign want    = periodic || pend || req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      running <= 1'b0;
      pend    <= 1'b0;
      sync_o  <= 1'b0;
      start_o <= 1'b0;
    end else if (!active) begin
      pos     <= '0;
      running <= 1'b0;
      pend    <= 1'b0;
      sync_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (req) pend <= 1'b1;
      if (tick) begin
        if (running && !at_end) begin
          pos    <= nxt;
          sync_o <= (nxt <= wid_ext);
        end else if (want) begin
          pos     <= '0;
          running <= 1'b1;
          sync_o  <= 1'b1;
          start_o <= 1'b1;
          if (!periodic) pend <= 1'b0;
        end else begin
          pos     <= '0;
          running <= 1'b0;
          sync_o  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsg_pkg::*;
#(
  parameter int unsigned DIVW = DIV_W,
  parameter int unsigned PERW = PER_W,
  parameter int unsigned WIDW = WID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_en,
  input  logic            fs_en,
  input  logic            ext_sel,
  input  logic            ext_clk,
  input  logic [DIVW-1:0] clk_div,
  input  logic [PERW-1:0] period,
  input  logic [WIDW-1:0] width,
  input  logic            sync_mode,
  input  logic            tx_load,
  output logic            bclk,
  output logic            bclk_rise,
  output logic            fsync,
  output logic            frame_start
);
  clk_src_e   src;
  sync_kind_e kind;
  logic       sync_active;

  assign src         = clk_src_e'(ext_sel);
  assign kind        = sync_kind_e'(sync_mode);
  assign sync_active = gen_en & fs_en;

  fsg_clkdiv #(.DW(DIVW), .NSYNC(SYNC_LEN)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gen_en),
    .use_ext  (src == SRC_EXTERNAL),
    .ext_clk  (ext_clk),
    .div      (clk_div),
    .bit_lvl  (bclk),
    .bit_rise (bclk_rise)
  );

  fsg_framer #(.PW(PERW), .WW(WIDW)) u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (sync_active),
    .tick     (bclk_rise),
    .periodic (kind == SYNC_PERIOD),
    .req      (tx_load),
    .per      (period),
    .wid      (width),
    .sync_o   (fsync),
    .start_o  (frame_start)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int unsigned PERW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gen_en,
  input logic            fs_en,
  input logic            sync_mode,
  input logic [PERW-1:0] period,
  input logic            bclk,
  input logic            bclk_rise,
  input logic            fsync,
  input logic            frame_start
);
  logic [PERW:0]   tcnt;
  logic [PERW-1:0] per_q;
  logic            trk;
  logic            cfg_ok;

  assign cfg_ok = gen_en && fs_en && sync_mode && (period == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      per_q <= '0;
      trk   <= 1'b0;
    end else begin
      per_q <= period;
      if (frame_start)    tcnt <= '0;
      else if (bclk_rise) tcnt <= tcnt + 1'b1;
      if (!cfg_ok)          trk <= 1'b0;
      else if (frame_start) trk <= 1'b1;
    end
  end

  a_r1_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> bclk);
  a_r3_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(bclk_rise));
  a_r3_period: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && trk && cfg_ok) |-> (tcnt == ({1'b0, period} + 1'b1)));
  a_r4_start_sync: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> fsync);
  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> frame_start);
  a_r6_sync_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_en |=> (!fsync && !frame_start));
  a_r7_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!bclk && !bclk_rise && !fsync && !frame_start));
endmodule

bind fsync_gen fsg_checker #(.PERW(PERW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gen_en      (gen_en),
  .fs_en       (fs_en),
  .sync_mode   (sync_mode),
  .period      (period),
  .bclk        (bclk),
  .bclk_rise   (bclk_rise),
  .fsync       (fsync),
  .frame_start (frame_start)
);

// File: tb/sim_fsync_gen.sv
module sim_fsync_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b0, fs_en = 1'b0, ext_sel = 1'b0, ext_clk = 1'b0;
  logic [7:0]  clk_div = '0;
  logic [11:0] period = '0;
  logic [7:0]  width = '0;
  logic        sync_mode = 1'b1, tx_load = 1'b0;
  logic        bclk, bclk_rise, fsync, frame_start;

  int checks = 0, fails = 0;
  logic [1:0] sq[$];
  string cur_req = "R3/R4";
  bit arm = 0, pend_m = 0, ext_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_gen u0 (.clk, .rst_n, .gen_en, .fs_en, .ext_sel, .ext_clk, .clk_div,
    .period, .width, .sync_mode, .tx_load, .bclk, .bclk_rise, .fsync, .frame_start);

  // slow external serial clock: 3 clocks high, 3 low
  initial forever begin
    repeat (3) @(posedge clk);
    #2 ext_clk = ext_run ? ~ext_clk : 1'b0;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: one expected {fsync, frame_start} pair per armed bit clock
  always @(negedge clk) begin
    if (pend_m && sq.size() > 0) begin
      logic [1:0] e;
      e = sq.pop_front();
      check({cur_req, " fsync"}, fsync, e[1]);
      check({cur_req, " frame_start"}, frame_start, e[0]);
    end
    pend_m = arm && bclk_rise;
  end

  task automatic push_frames(input int p, input int w, input int n);
    for (int k = 0; k < n; k++)
      sq.push_back({((k % (p + 1)) <= w), ((k % (p + 1)) == 0)});
  endtask

  task automatic align();
    do begin @(posedge clk); #1; end while (bclk_rise);
  endtask

  task automatic measure(input string req, input int exp);
    int n;
    do begin @(posedge clk); #1; end while (!bclk_rise);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!bclk_rise);
    check(req, n, exp);
  endtask

  task automatic drain();
    while (sq.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1 arm = 0; fs_en = 0; gen_en = 0;
    repeat (4) @(posedge clk);
  endtask

  task automatic run_periodic(input string req, input int div, input bit ext,
                              input int p, input int w, input int n, input int sp);
    #1 clk_div = 8'(div); ext_sel = ext; ext_run = ext; period = 12'(p);
    width = 8'(w); sync_mode = 1'b1; gen_en = 1;
    repeat (12) @(posedge clk);
    measure(ext ? "R2 spacing" : "R1 spacing", sp);
    cur_req = req;
    push_frames(p, w, n);
    align();
    fs_en = 1; arm = 1;
    drain();
    ext_run = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("reset bclk", bclk, 0);
    check("reset fsync", fsync, 0);
    check("reset frame_start", frame_start, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // R1 R3 R4: divide by 1, short frame
    run_periodic("R3/R4 a", 0, 0, 7, 3, 24, 2);
    // R1 R3 R4: 32-bit frame, 16-bit sync, divider 2
    run_periodic("R3/R4 b", 2, 0, 31, 15, 64, 6);
    // R5: width beyond period
    run_periodic("R5", 1, 0, 5, 9, 18, 4);
    // R2: external clock, width 0
    run_periodic("R2/R4 ext", 0, 1, 3, 0, 12, 6);

    // R6: clock runs, sync stage held
    #1 clk_div = 0; ext_sel = 0; period = 3; width = 1; gen_en = 1; fs_en = 0;
    begin
      int seen_fs = 0, seen_st = 0, seen_tick = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        seen_fs |= fsync; seen_st |= frame_start; seen_tick |= bclk_rise;
      end
      check("R6 fsync held", seen_fs, 0);
      check("R6 frame_start held", seen_st, 0);
      check("R6 clock runs", seen_tick, 1);
    end

    // R7: generator off clears everything even with fs_en high
    @(posedge clk); #1 fs_en = 1;
    repeat (10) @(posedge clk);
    #1 gen_en = 0;
    @(posedge clk);
    begin
      int any = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        any |= bclk | bclk_rise | fsync | frame_start;
      end
      check("R7 all low", any, 0);
    end
    #1 fs_en = 0;
    repeat (3) @(posedge clk);

    // R8: transmit-tied, second request mid-frame chains a frame
    #1 clk_div = 0; period = 5; width = 2; sync_mode = 0; gen_en = 1; fs_en = 1;
    repeat (12) @(posedge clk);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= fsync; end
      check("R8 idle without request", seen, 0);
    end
    cur_req = "R8";
    push_frames(5, 2, 12);
    for (int k = 0; k < 6; k++) sq.push_back(2'b00);
    align();
    tx_load = 1; arm = 1;
    @(posedge clk); #1 tx_load = 0;
    repeat (3) @(posedge clk);
    #1 tx_load = 1;
    @(posedge clk); #1 tx_load = 0;
    drain();

    finish_run();
  end
endmodule